// File: doc/BRIEF.md
# Predicated Execution Gate with Window Sequencer

This block decides, in each cycle, whether the instruction currently presented may execute. It evaluates a 4-bit condition code against the four status flags (negative, zero, carry, overflow) and drives a single execute-enable bit. The result is combinational from the current inputs and the held state, so it is valid in the same cycle.

The block also holds an 8-bit predication window register. This register describes a short run of up to four following instructions that take their condition from the window and not from their own encoding. The upper nibble of the window is the condition that applies to the current instruction. The lower nibble is a mask whose lowest set bit marks the end of the run. A step strobe, pulsed once for each retired instruction inside the run, shifts the mask. The lowest condition bit follows the shifted-out mask bit, which gives then/else behaviour. When the run is finished the whole register clears. A load strobe writes a fresh window value, and it wins over a step in the same cycle. Reset is synchronous and active high.

Top module: `pred_gate`

## Requirements
- R1: Condition codes 4'b1110 and 4'b1111 make `exec_o` high for every flag combination. Flags are packed as `flags_i[3]`=N, `flags_i[2]`=Z, `flags_i[1]`=C, `flags_i[0]`=V.
- R2: The single-flag codes pass as follows. 0000 passes when Z=1 and 0001 when Z=0. 0010 passes when C=1 and 0011 when C=0. 0100 passes when N=1 and 0101 when N=0. 0110 passes when V=1 and 0111 when V=0.
- R3: Code 1000 passes only when C=1 and Z=0. Code 1001 passes in every other flag case.
- R4: Code 1010 passes when N equals V. Code 1011 passes when N differs from V.
- R5: Code 1100 passes when Z=0 and N equals V. Code 1101 passes when Z=1 or N differs from V.
- R6: `in_win_o` is high exactly when `win_o[3:0]` is nonzero. While it is high, the condition evaluated is `win_o[7:4]`, and `cond_i` has no effect.
- R7: A step (with no load) that leaves a nonzero mask updates the window as follows. Bits [7:5] keep their value, and bits [4:0] become the old bits [3:0] shifted left by one with a 0 entering at bit 0.
- R8: A step that would leave bits [3:0] zero clears the whole window to 8'h00. A run whose mask has its lowest set bit at position 4-n therefore lasts exactly n instructions, for n from 1 to 4.
- R9: A load writes `load_val_i` into the window on the next edge, and this takes priority over a step in the same cycle.
- R10: Reset clears the window to 8'h00. A step applied to an empty window leaves it at 8'h00.
- R11: With neither load nor step asserted, the window holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cond_i | input | 4 | Condition code of the current instruction |
| flags_i | input | 4 | Status flags {N, Z, C, V} |
| step_i | input | 1 | One instruction retired inside the window |
| load_i | input | 1 | Write a new window value |
| load_val_i | input | 8 | Window value to write |
| exec_o | output | 1 | Current instruction may execute |
| win_o | output | 8 | Current window register |
| in_win_o | output | 1 | A predication window is active |

## Verification
On every cycle, the assertions check the window register's transitions: the shift and keep on a step, the clear at the end of a run, the priority of a load, holding when idle, and the effect of reset. They also check that the always-pass codes and an always-pass window condition raise the enable. The full truth table of the sixteen codes against the sixteen flag patterns, the way the window overrides the instruction's own code, and runs of exactly one to four instructions with mixed then/else slots can only be shown by the bench's scenarios, which compare each cycle against an independent model.

// File: rtl/pred_pkg.sv
package pred_pkg;

    localparam int CODE_W = 4;
    localparam int FLAG_W = 4;

    // flag bit positions inside the packed flag vector
    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_C = 1;
    localparam int FLG_V = 0;

    // base tests selected by code bits [3:1]; code bit 0 inverts (except 3'b111)
    typedef enum logic [2:0] {
        BASE_ZERO  = 3'd0,
        BASE_CARRY = 3'd1,
        BASE_NEG   = 3'd2,
        BASE_OVF   = 3'd3,
        BASE_HIGH  = 3'd4,
        BASE_SGE   = 3'd5,
        BASE_SGT   = 3'd6,
        BASE_ALL   = 3'd7
    } base_test_e;

endpackage

// File: rtl/cond_eval.sv
module cond_eval
    import pred_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic              pass_o
);

    logic       n_f, z_f, c_f, v_f;
    logic       base_hit;
    base_test_e base_sel;

    assign n_f = flags_i[FLG_N];
    assign z_f = flags_i[FLG_Z];
    assign c_f = flags_i[FLG_C];
    assign v_f = flags_i[FLG_V];

    assign base_sel = base_test_e'(code_i[CODE_W-1:1]);

    always_comb begin
        unique case (base_sel)
            BASE_ZERO:  base_hit = z_f;
            BASE_CARRY: base_hit = c_f;
            BASE_NEG:   base_hit = n_f;
            BASE_OVF:   base_hit = v_f;
            BASE_HIGH:  base_hit = c_f & ~z_f;
            BASE_SGE:   base_hit = (n_f == v_f);
            BASE_SGT:   base_hit = ~z_f & (n_f == v_f);
            default:    base_hit = 1'b1;
        endcase
    end

    // odd codes are the complement, except the always-pass pair
    assign pass_o = (base_sel == BASE_ALL) ? 1'b1 : (base_hit ^ code_i[0]);

endmodule

// File: rtl/window_seq.sv
module window_seq #(
    parameter int STATE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step_i,
    input  logic               load_i,
    input  logic [STATE_W-1:0] load_val_i,
    output logic [STATE_W-1:0] state_o,
    output logic               active_o
);

    localparam int HALF = STATE_W / 2;

    typedef struct packed {
        logic [STATE_W-1:0] state;
    } win_regs_t;

    win_regs_t regs_d, regs_q;
    logic [STATE_W-1:0] shifted;
    logic               last_slot;

    // upper bits above the condition LSB stay; mask plus condition LSB shift up
    assign shifted   = {regs_q.state[STATE_W-1:HALF+1], regs_q.state[HALF-1:0], 1'b0};
    assign last_slot = (regs_q.state[HALF-2:0] == '0);

    always_comb begin
        regs_d = regs_q;
        if (load_i) begin
            regs_d.state = load_val_i;
        end else if (step_i) begin
            regs_d.state = last_slot ? '0 : shifted;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_o  = regs_q.state;
    assign active_o = (regs_q.state[HALF-1:0] != '0);

    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (state_o == '0));

    assert_load_wins_R9: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (state_o == $past(load_val_i)));

    assert_step_shift_R7: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i && state_o[HALF-2:0] != '0) |=>
        (state_o[STATE_W-1:HALF+1] == $past(state_o[STATE_W-1:HALF+1]) &&
         state_o[HALF:0] == {$past(state_o[HALF-1:0]), 1'b0}));

    assert_run_end_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i && state_o[HALF-2:0] == '0) |=> (state_o == '0));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !load_i) |=> $stable(state_o));

endmodule

// File: rtl/pred_gate.sv
module pred_gate #(
    parameter int STATE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [STATE_W/2-1:0] cond_i,
    input  logic [3:0]           flags_i,
    input  logic                 step_i,
    input  logic                 load_i,
    input  logic [STATE_W-1:0]   load_val_i,
    output logic                 exec_o,
    output logic [STATE_W-1:0]   win_o,
    output logic                 in_win_o
);

    localparam int CW = STATE_W / 2;

    logic [STATE_W-1:0] win_state;
    logic               win_active;
    logic [CW-1:0]      eff_code;

    window_seq #(.STATE_W(STATE_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .step_i     (step_i),
        .load_i     (load_i),
        .load_val_i (load_val_i),
        .state_o    (win_state),
        .active_o   (win_active)
    );

    assign eff_code = win_active ? win_state[STATE_W-1:CW] : cond_i;

    cond_eval u_eval (
        .code_i  (eff_code),
        .flags_i (flags_i),
        .pass_o  (exec_o)
    );

    assign win_o    = win_state;
    assign in_win_o = win_active;

    assert_always_pass_R1: assert property (@(posedge clk) disable iff (rst)
        (!in_win_o && cond_i[CW-1:1] == 3'b111) |-> exec_o);

    assert_window_code_R6: assert property (@(posedge clk) disable iff (rst)
        (in_win_o && win_o[STATE_W-1:CW+1] == 3'b111) |-> exec_o);

endmodule

// File: tb/pred_gate_bench.sv
module pred_gate_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] cond_i = '0;
    logic [3:0] flags_i = '0;
    logic       step_i = 1'b0;
    logic       load_i = 1'b0;
    logic [7:0] load_val_i = '0;
    logic       exec_o;
    logic [7:0] win_o;
    logic       in_win_o;

    always #4 clk = ~clk;

    pred_gate u_pred_gate (
        .clk(clk), .rst(rst), .cond_i(cond_i), .flags_i(flags_i),
        .step_i(step_i), .load_i(load_i), .load_val_i(load_val_i),
        .exec_o(exec_o), .win_o(win_o), .in_win_o(in_win_o)
    );

    typedef struct {
        string      tag;
        logic       ex;
        logic [7:0] w;
        logic       iw;
    } exp_t;

    exp_t       sb[$];
    int         total = 0;
    int         fails = 0;
    logic [7:0] model = 8'h00;
    bit         done = 0;

    function automatic logic ref_pass(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        n = f[3]; z = f[2]; cy = f[1]; v = f[0];
        case (c)
            4'h0: return z;
            4'h1: return !z;
            4'h2: return cy;
            4'h3: return !cy;
            4'h4: return n;
            4'h5: return !n;
            4'h6: return v;
            4'h7: return !v;
            4'h8: return cy && !z;
            4'h9: return !cy || z;
            4'hA: return n == v;
            4'hB: return n != v;
            4'hC: return !z && (n == v);
            4'hD: return z || (n != v);
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] ref_step(input logic [7:0] w);
        logic [7:0] r;
        r = {w[7:5], w[3:0], 1'b0};
        if (r[3:0] == 4'h0) r = 8'h00;
        return r;
    endfunction

    // driver: set inputs, push expectation for this cycle, advance the model
    task automatic apply(input logic [3:0] c, input logic [3:0] f, input logic st,
                         input logic ld, input logic [7:0] v, input string tag);
        exp_t e;
        logic [3:0] eff;
        @(negedge clk);
        cond_i = c; flags_i = f; step_i = st; load_i = ld; load_val_i = v;
        eff = (model[3:0] != 0) ? model[7:4] : c;
        e.tag = tag; e.ex = ref_pass(eff, f); e.w = model; e.iw = (model[3:0] != 0);
        sb.push_back(e);
        if (ld) model = v;
        else if (st) model = ref_step(model);
    endtask

    // monitor: compare mid-cycle, away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (exec_o !== e.ex || win_o !== e.w || in_win_o !== e.iw) begin
                    fails++;
                    $display("FAIL %s: got exec=%b win=%h in=%b expected exec=%b win=%h in=%b",
                             e.tag, exec_o, win_o, in_win_o, e.ex, e.w, e.iw);
                end
            end
        end
    end

    task automatic run_window(input logic [7:0] val, input int len, input logic [3:0] f);
        apply(4'hE, f, 1'b0, 1'b1, val, "R9 load");
        for (int k = 0; k < len; k++) begin
            apply(4'hE, f, 1'b1, 1'b0, 8'h00, (k == len - 1) ? "R8 last slot" : "R6 R7 slot");
        end
        apply(4'hE, f, 1'b0, 1'b0, 8'h00, "R8 window closed");
    endtask

    initial begin
        // reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model = 8'h00;
        apply(4'h0, 4'h4, 1'b0, 1'b0, 8'h00, "R10 reset state");
        // truth table, no window
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                string t;
                if (c >= 14) t = "R1 always";
                else if (c < 8) t = "R2 single flag";
                else if (c < 10) t = "R3 high/low-same";
                else if (c < 12) t = "R4 signed ge/lt";
                else t = "R5 signed gt/le";
                apply(c[3:0], f[3:0], 1'b0, 1'b0, 8'h00, t);
            end
        end
        // step on empty window stays empty
        apply(4'h0, 4'h0, 1'b1, 1'b0, 8'h00, "R10 step empty");
        apply(4'h0, 4'h0, 1'b0, 1'b0, 8'h00, "R10 still empty");
        // runs of one to four with mixed then/else; Z clear so EQ fails, NE passes
        run_window(8'h08, 1, 4'h0);
        run_window(8'h0C, 2, 4'h0);
        run_window(8'h1A, 3, 4'h4);
        run_window(8'h0B, 4, 4'h0);
        run_window(8'hA5, 4, 4'h9);
        run_window(8'hC6, 3, 4'h2);
        // cond_i ignored inside window: window says EQ, Z clear, instruction says AL
        apply(4'hE, 4'h0, 1'b0, 1'b1, 8'h08, "R9 load");
        apply(4'hE, 4'h0, 1'b0, 1'b0, 8'h00, "R6 cond_i ignored");
        apply(4'hF, 4'h0, 1'b0, 1'b0, 8'h00, "R11 hold");
        apply(4'h1, 4'h0, 1'b0, 1'b0, 8'h00, "R11 hold");
        // load beats step
        apply(4'h0, 4'h0, 1'b1, 1'b1, 8'h2C, "R9 load vs step");
        apply(4'h0, 4'h0, 1'b0, 1'b0, 8'h00, "R9 after priority");
        // window with empty mask but nonzero condition: step clears
        apply(4'h0, 4'h0, 1'b0, 1'b1, 8'h30, "R9 load");
        apply(4'h0, 4'h4, 1'b1, 1'b0, 8'h00, "R6 inactive window");
        apply(4'h0, 4'h4, 1'b0, 1'b0, 8'h00, "R8 cleared");
        // reset in the middle of a window
        apply(4'h0, 4'h0, 1'b0, 1'b1, 8'hAB, "R9 load");
        @(negedge clk);
        rst = 1'b1;
        step_i = 1'b0; load_i = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        model = 8'h00;
        sb.push_back('{tag: "R10 flushed", ex: 1'b1, w: 8'h00, iw: 1'b0});
        cond_i = 4'hE;
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            fails++; total++;
            $display("FAIL R11 scoreboard: got %0d pending expected 0", sb.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule